// File: doc/BRIEF.md
# Multi-Mode Host Bus Register Front End

This block connects an 8-bit host bus to an internal bank of registers. The same set of host pins carries one of three bus styles, picked by a two-bit mode input that is held steady after reset. Two of the styles are asynchronous. In the latch-enable style, a high-active address latch enable pin frames the address, and separate low-active read and write strobes follow it. In the strobe-pair style, a low-active address strobe frames the address, and a low-active data strobe together with a read/write direction line completes the cycle. The third style is synchronous: every pin is sampled on the rising edge of the bus clock.

In the asynchronous styles, the control pins and the bus values pass through a short synchronizer chain into the bus clock domain. Edges of the control pins are then detected there. An address-framing edge loads the address latch. The assertion edge of a write strobe produces exactly one single-cycle write on the internal register port. In the synchronous style, the register port is driven straight from the pins, so a write lands on the same clock edge that sees it. The read data bus is modelled as a data output plus an output enable. When the enable is low, the bus is released.

Top module: `hbus_front`

## Requirements
- R1: With `bus_mode` = 2'b00 (latch-enable style), a high-to-low transition of `ale_as` while `cs_n` is low loads `addr_in` into the address latch. `reg_addr` shows that address afterwards, until the next such transition.
- R2: With `bus_mode` = 2'b01 (strobe-pair style), a low-to-high transition of `ale_as` (the low-active address strobe) while `cs_n` is low loads `addr_in` into the address latch, which `reg_addr` then shows.
- R3: With `bus_mode` = 2'b00, `data_oe` is 1 exactly while `cs_n` and `rd_ds_n` are both low. While it is 1, `data_out` equals `reg_rdata`.
- R4: With `bus_mode` = 2'b01, `data_oe` is 1 exactly while `cs_n` and `rd_ds_n` are low and `wr_rw` is high (the read direction). While it is 1, `data_out` equals `reg_rdata`.
- R5: In both asynchronous styles, the assertion (falling) edge of the write strobe with `cs_n` low produces exactly one `reg_wr_en` pulse, one cycle long, within four clock cycles. The pulse carries `reg_wdata` equal to `data_in` and `reg_addr` equal to the latched address. In style 2'b00 the write strobe is `wr_rw`. In style 2'b01 it is `rd_ds_n`, and `wr_rw` must be low (the write direction).
- R6: With `bus_mode[1]` = 1 (2'b10 is the synchronous style, and the reserved 2'b11 behaves identically), `reg_wr_en` is high in every cycle in which `cs_n`, `wr_rw` and `rd_ds_n` are all low. The register takes `data_in` at `addr_in` on that same clock edge.
- R7: In the synchronous style, `ale_as` is ignored. Toggling it changes neither `reg_addr` (which follows `addr_in`), nor the read data, nor the write count.
- R8: In the synchronous style, `data_oe` is 1 exactly while `cs_n` is low and `wr_rw` is high. `data_out` then shows the register at `addr_in`.
- R9: While `cs_n` is high, `data_oe` stays 0, no write occurs, and the address latch keeps its value, in every style.
- R10: During and right after reset, `reg_wr_en` is 0, the address latch reads 0, and `data_oe` is 0 while the pins are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 2 | 00 latch-enable style, 01 strobe-pair style, 1x synchronous |
| cs_n | input | 1 | Chip select, active low |
| ale_as | input | 1 | Address latch enable (00), address strobe low-active (01), ignored (1x) |
| rd_ds_n | input | 1 | Read strobe (00), data strobe (01), write enable (1x), all low-active |
| wr_rw | input | 1 | Write strobe low-active (00), direction 1=read 0=write (01 and 1x) |
| addr_in | input | 15 | Host address |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Host read data |
| data_oe | output | 1 | Drive enable for the host data bus |
| reg_addr | output | 15 | Register port address |
| reg_wdata | output | 8 | Register port write data |
| reg_wr_en | output | 1 | Register port write enable, one per write |
| reg_rdata | input | 8 | Register port read data (combinational) |

## Verification
A wrong address latch shows up on the next read as data from a different register. It also shows up at once on `reg_addr` after the latching edge settles, which is about three clock cycles. A faulty edge detector shows up as a missing or doubled write pulse, so the bench counts pulses per bus cycle and records the address and data each pulse carries. Read-drive decoding errors are visible in the same cycle, because `data_oe` follows the pins combinationally.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [1:0] {
        BM_LATCH    = 2'b00,
        BM_STROBE   = 2'b01,
        BM_SYNC     = 2'b10,
        BM_SYNC_ALT = 2'b11
    } bus_mode_e;

    // Control pins of the host bus, grouped for the synchronizer
    typedef struct packed {
        logic cs_n;
        logic ale_as;
        logic rd_ds_n;
        logic wr_rw;
    } pin_ctl_t;

    localparam int CTL_W = $bits(pin_ctl_t);

    // Reserved encoding 2'b11 folds onto the synchronous style
    function automatic logic mode_is_sync(bus_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_latch(bus_mode_e m);
        return m == BM_LATCH;
    endfunction

    function automatic logic mode_is_strobe(bus_mode_e m);
        return m == BM_STROBE;
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    stg[0] <= d;
                end
            end else begin : g_rest
                // reset preloads the live pin value so no false edge follows
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= d;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_async_ctrl.sv
module hbus_async_ctrl
    import hbus_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_mode_e     mode,
    input  pin_ctl_t      ctl_now,
    input  logic [AW-1:0] addr_prev,
    input  logic [DW-1:0] data_now,
    output logic [AW-1:0] addr_lat,
    output logic [DW-1:0] wdata_q,
    output logic          wr_pulse
);
    pin_ctl_t ctl_prev;
    logic     sel_ok;
    logic     load_evt;
    logic     wr_evt;

    always_ff @(posedge clk) begin
        if (rst) ctl_prev <= ctl_now;
        else     ctl_prev <= ctl_now;
    end

    // chip select must hold across the detected edge
    assign sel_ok = !ctl_now.cs_n && !ctl_prev.cs_n;

    always_comb begin
        load_evt = 1'b0;
        wr_evt   = 1'b0;
        if (sel_ok) begin
            if (mode_is_latch(mode)) begin
                load_evt = ctl_prev.ale_as && !ctl_now.ale_as;
                wr_evt   = ctl_prev.wr_rw  && !ctl_now.wr_rw;
            end else if (mode_is_strobe(mode)) begin
                load_evt = !ctl_prev.ale_as && ctl_now.ale_as;
                wr_evt   = ctl_prev.rd_ds_n && !ctl_now.rd_ds_n && !ctl_now.wr_rw;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lat <= '0;
            wdata_q  <= '0;
            wr_pulse <= 1'b0;
        end else begin
            if (load_evt) addr_lat <= addr_prev;
            if (wr_evt)   wdata_q  <= data_now;
            wr_pulse <= wr_evt;
        end
    end
endmodule

// File: rtl/hbus_read_drive.sv
module hbus_read_drive
    import hbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  bus_mode_e     mode,
    input  pin_ctl_t      pins,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] dout,
    output logic          oe
);
    always_comb begin
        oe = 1'b0;
        if (!pins.cs_n) begin
            if (mode_is_sync(mode))        oe = pins.wr_rw;
            else if (mode_is_latch(mode))  oe = !pins.rd_ds_n;
            else                           oe = !pins.rd_ds_n && pins.wr_rw;
        end
    end

    assign dout = oe ? rdata : '0;
endmodule

// File: rtl/hbus_front.sv
module hbus_front
    import hbus_pkg::*;
#(
    parameter int AW          = 15,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bus_mode,
    input  logic          cs_n,
    input  logic          ale_as,
    input  logic          rd_ds_n,
    input  logic          wr_rw,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_wr_en,
    input  logic [DW-1:0] reg_rdata
);
    localparam int ADDR_STAGES = SYNC_STAGES + 1;

    bus_mode_e     mode;
    pin_ctl_t      pins_raw;
    pin_ctl_t      pins_sync;
    logic [CTL_W-1:0] pins_sync_v;
    logic [AW-1:0] addr_prev;
    logic [DW-1:0] data_now;
    logic [AW-1:0] addr_lat;
    logic [DW-1:0] wdata_q;
    logic          wr_pulse;
    logic          sync_wr;

    assign mode     = bus_mode_e'(bus_mode);
    assign pins_raw = '{cs_n: cs_n, ale_as: ale_as, rd_ds_n: rd_ds_n, wr_rw: wr_rw};

    hbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk (clk), .rst (rst), .d (pins_raw), .q (pins_sync_v)
    );
    assign pins_sync = pin_ctl_t'(pins_sync_v);

    // address trails the controls by one stage: value just before the edge
    hbus_sync #(.W(AW), .STAGES(ADDR_STAGES)) u_addr_sync (
        .clk (clk), .rst (rst), .d (addr_in), .q (addr_prev)
    );

    hbus_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_data_sync (
        .clk (clk), .rst (rst), .d (data_in), .q (data_now)
    );

    hbus_async_ctrl #(.AW(AW), .DW(DW)) u_actl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .ctl_now   (pins_sync),
        .addr_prev (addr_prev),
        .data_now  (data_now),
        .addr_lat  (addr_lat),
        .wdata_q   (wdata_q),
        .wr_pulse  (wr_pulse)
    );

    hbus_read_drive #(.DW(DW)) u_rd (
        .mode  (mode),
        .pins  (pins_raw),
        .rdata (reg_rdata),
        .dout  (data_out),
        .oe    (data_oe)
    );

    // synchronous style: the register bank samples the pins on this edge
    assign sync_wr = !cs_n && !wr_rw && !rd_ds_n && !rst;

    always_comb begin
        if (mode_is_sync(mode)) begin
            reg_addr  = addr_in;
            reg_wdata = data_in;
            reg_wr_en = sync_wr;
        end else begin
            reg_addr  = addr_lat;
            reg_wdata = wdata_q;
            reg_wr_en = wr_pulse;
        end
    end
endmodule

// File: rtl/hbus_front_chk.sv
module hbus_front_chk #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    bus_mode,
    input logic          cs_n,
    input logic          ale_as,
    input logic          rd_ds_n,
    input logic [DW-1:0] data_in,
    input logic [DW-1:0] data_out,
    input logic          data_oe,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          reg_wr_en,
    input logic [DW-1:0] reg_rdata
);
    // R5: an asynchronous write is a single-cycle pulse
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (!bus_mode[1] && reg_wr_en) |=> !reg_wr_en);

    // R9: no bus drive while deselected
    p_idle_cs_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !data_oe);

    // R3: read strobe in latch-enable style drives the register data
    p_read_drive_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_mode == 2'b00 && !cs_n && !rd_ds_n) |-> (data_oe && data_out == reg_rdata));

    // R1, R2: latched address holds while the framing pin is quiet
    p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!bus_mode[1] && $stable(bus_mode) && $stable(ale_as) && $past(ale_as, 2) == ale_as
         && $past(ale_as, 3) == ale_as && $past(ale_as, 4) == ale_as) |-> $stable(reg_addr));

    // R6: synchronous write carries the data pins on the same edge
    p_sync_wdata_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_mode[1] && reg_wr_en) |-> (reg_wdata == data_in && !cs_n));
endmodule

bind hbus_front hbus_front_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_mode  (bus_mode),
    .cs_n      (cs_n),
    .ale_as    (ale_as),
    .rd_ds_n   (rd_ds_n),
    .data_in   (data_in),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr_en (reg_wr_en),
    .reg_rdata (reg_rdata)
);

// File: tb/tb_hbus_front.sv
`timescale 1ns/1ps
module tb_hbus_front;
    localparam int AW = 15;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    bus_mode;
    logic          cs_n, ale_as, rd_ds_n, wr_rw;
    logic [AW-1:0] addr_in;
    logic [DW-1:0] data_in;
    logic [DW-1:0] data_out;
    logic          data_oe;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic          reg_wr_en;
    logic [DW-1:0] reg_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hbus_front dut (
        .clk (clk), .rst (rst), .bus_mode (bus_mode), .cs_n (cs_n),
        .ale_as (ale_as), .rd_ds_n (rd_ds_n), .wr_rw (wr_rw),
        .addr_in (addr_in), .data_in (data_in), .data_out (data_out),
        .data_oe (data_oe), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_wr_en (reg_wr_en), .reg_rdata (reg_rdata)
    );

    // register bank model: 16 registers at addresses 0..15, others read 0
    logic [DW-1:0] bank [16];
    logic [DW-1:0] shadow [16];
    int            wr_count = 0;
    logic [AW-1:0] last_wa;
    logic [DW-1:0] last_wd;

    assign reg_rdata = (reg_addr < 16) ? bank[reg_addr[3:0]] : '0;

    always @(posedge clk) begin
        if (reg_wr_en) begin
            wr_count <= wr_count + 1;
            last_wa  <= reg_addr;
            last_wd  <= reg_wdata;
            if (reg_addr < 16) bank[reg_addr[3:0]] <= reg_wdata;
        end
    end

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        return (a < 16) ? shadow[a[3:0]] : '0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_idle(input logic [1:0] m);
        cs_n = 1'b1; rd_ds_n = 1'b1; wr_rw = 1'b1;
        ale_as = (m == 2'b01);
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; bus_mode = m; set_idle(m);
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
    endtask

    task automatic latch_addr(input logic [1:0] m, input logic [AW-1:0] a);
        cs_n = 1'b0; addr_in = a;
        ale_as = (m == 2'b00);
        wait_clk(1);
        ale_as = (m == 2'b01);
        wait_clk(5);
    endtask

    task automatic bus_write(input logic [1:0] m, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        if (m[1]) begin
            cs_n = 1'b0; addr_in = a; data_in = d; wr_rw = 1'b0; rd_ds_n = 1'b0;
            @(negedge clk);
            set_idle(m);
        end else begin
            latch_addr(m, a);
            data_in = d;
            if (m == 2'b00) wr_rw = 1'b0;
            else begin wr_rw = 1'b0; rd_ds_n = 1'b0; end
            wait_clk(5);
            set_idle(m);
            wait_clk(2);
        end
        if (a < 16) shadow[a[3:0]] = d;
    endtask

    task automatic bus_read(input logic [1:0] m, input logic [AW-1:0] a,
                            output logic [DW-1:0] d, output logic oe);
        @(negedge clk);
        if (!m[1]) latch_addr(m, a);
        cs_n = 1'b0; addr_in = a; wr_rw = 1'b1;
        if (!m[1]) rd_ds_n = 1'b0;
        #1;
        d = data_out; oe = data_oe;
        @(negedge clk);
        set_idle(m);
        wait_clk(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] rd;
        logic          oe;
        int            c0;
        logic [1:0]    cur_mode;
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 16; i++) begin bank[i] = '0; shadow[i] = '0; end
        addr_in = '0; data_in = '0; rst = 1'b1;
        bus_mode = 2'b00; set_idle(2'b00);

        // R10: reset state
        do_reset(2'b00);
        #1;
        check("R10 wr_en", reg_wr_en, 0);
        check("R10 addr latch", reg_addr, 0);
        check("R10 oe idle", data_oe, 0);
        wait_clk(1);

        // R1 / R5: latch-enable style write
        c0 = wr_count;
        bus_write(2'b00, 15'd5, 8'hA5);
        check("R5 one pulse mode00", wr_count - c0, 1);
        check("R5 pulse addr", last_wa, 5);
        check("R5 pulse data", last_wd, 8'hA5);
        check("R1 latched addr", reg_addr, 5);

        // R3: read drive
        bus_read(2'b00, 15'd5, rd, oe);
        check("R3 oe", oe, 1);
        check("R3 data", rd, 8'hA5);
        #1 check("R3 released", data_oe, 0);

        // R9: deselected bus does nothing
        @(negedge clk);
        c0 = wr_count;
        cs_n = 1'b1; addr_in = 15'd9; ale_as = 1'b1;
        wait_clk(1); ale_as = 1'b0; wait_clk(2);
        wr_rw = 1'b0; rd_ds_n = 1'b0; #1;
        check("R9 no drive", data_oe, 0);
        wait_clk(5);
        set_idle(2'b00); wait_clk(2);
        check("R9 no write", wr_count - c0, 0);
        check("R9 latch kept", reg_addr, 5);
        cs_n = 1'b0; rd_ds_n = 1'b0; #1;
        check("R9 old addr data", data_out, 8'hA5);
        @(negedge clk); set_idle(2'b00);

        // R2 / R4 / R5: strobe-pair style
        do_reset(2'b01);
        c0 = wr_count;
        bus_write(2'b01, 15'd3, 8'h3C);
        check("R5 one pulse mode01", wr_count - c0, 1);
        check("R2 latched addr", reg_addr, 3);
        bus_read(2'b01, 15'd3, rd, oe);
        check("R4 oe", oe, 1);
        check("R4 data", rd, 8'h3C);
        // R4: data strobe with write direction does not drive
        @(negedge clk); cs_n = 1'b0; wr_rw = 1'b0; #1;
        check("R4 no drive write dir", data_oe, 0);
        @(negedge clk); set_idle(2'b01); wait_clk(6);

        // R6 / R8: synchronous style
        do_reset(2'b10);
        c0 = wr_count;
        bus_write(2'b10, 15'd7, 8'h81);
        wait_clk(1);
        check("R6 one write", wr_count - c0, 1);
        check("R6 data", last_wd, 8'h81);
        bus_read(2'b10, 15'd7, rd, oe);
        check("R8 oe", oe, 1);
        check("R8 data", rd, 8'h81);

        // R7: address strobe pin ignored
        @(negedge clk);
        c0 = wr_count;
        cs_n = 1'b0; wr_rw = 1'b1; addr_in = 15'd7;
        for (int k = 0; k < 6; k++) begin
            ale_as = ~ale_as; @(negedge clk);
        end
        #1;
        check("R7 addr follows", reg_addr, 7);
        check("R7 data", data_out, 8'h81);
        check("R7 no write", wr_count - c0, 0);
        set_idle(2'b10);

        // R6: reserved 2'b11 acts as synchronous
        do_reset(2'b11);
        c0 = wr_count;
        bus_write(2'b11, 15'd2, 8'h42);
        wait_clk(1);
        check("R6 mode11 write", wr_count - c0, 1);
        bus_read(2'b11, 15'd2, rd, oe);
        check("R6 mode11 data", rd, 8'h42);

        // random traffic across styles
        cur_mode = 2'b11;
        for (int it = 0; it < 40; it++) begin
            logic [1:0]    m;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            m = 2'($urandom_range(0, 3));
            a = ($urandom_range(0, 7) == 0) ? 15'($urandom_range(16, 32767)) : 15'($urandom_range(0, 15));
            d = 8'($urandom);
            if (m != cur_mode) begin do_reset(m); cur_mode = m; end
            c0 = wr_count;
            bus_write(m, a, d);
            wait_clk(1);
            check(m[1] ? "R6 rand count" : "R5 rand count", wr_count - c0, 1);
            check(m[1] ? "R6 rand addr" : "R5 rand addr", last_wa, a);
            bus_read(m, a, rd, oe);
            check(m[1] ? "R8 rand read" : (m == 2'b00 ? "R3 rand read" : "R4 rand read"),
                  {oe, rd}, {1'b1, exp_read(a)});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule